// File: doc/BRIEF.md
# Virtual Interrupt Deactivation Unit

This block takes write-only deactivate requests from a guest and applies them to a small bank of list entries that track virtual interrupts. Each entry holds a virtual interrupt ID, a two-bit lifecycle state, a flag marking it as backed by a physical interrupt, the physical interrupt ID and the physical group. A guest write carries an interrupt ID. The block finds the entry holding that ID, with no regard to the order in which interrupts became active, and retires the active part of its state.

When the retired entry is backed by a physical interrupt in Group 1, the block forwards a deactivate for the physical ID to the distributor over a valid/ready port. A write whose ID is in no entry adds one to a wrapping miss count. The hypervisor reads that count and can be alerted through a maintenance interrupt. The hypervisor loads entries through a write port and observes their states on a flat output. Guest writes act only while the end-of-interrupt split mode input is 1.

Top module: `vdeact_unit`

## Requirements
- R1: A request word is 32 bits wide. Bits 24:0 are the interrupt ID, and bits 31:25 are ignored.
- R2: The state encoding is 00 invalid, 01 pending, 10 active and 11 active-and-pending. A hit on an entry in state 10 sets it to 00.
- R3: A hit on an entry in state 11 sets it to 01.
- R4: A write that matches no entry in a state other than 00 adds one to the 5-bit miss count, which wraps from 31 to 0. A high `cnt_clr_i` zeroes the count on the next edge and takes precedence over an increment.
- R5: `maint_irq_o` is high exactly when the miss count is nonzero and `maint_en_i` is high.
- R6: A hit that retires an active entry with hardware flag 1 and group bit 1 raises `pd_valid_o` with that entry's physical ID. The valid and the ID stay unchanged until `pd_ready_i` is seen high at a clock edge.
- R7: When the retired entry has group bit 0, no physical deactivate is issued, but the state still changes.
- R8: A write accepted while `eoi_mode_i` is 0 changes no entry state and no count, forwards nothing and raises no error.
- R9: IDs 1020 to 1023 never match an entry, even one holding that ID, and count as a miss.
- R10: When several non-invalid entries hold the same ID, only the lowest-indexed one is updated.
- R11: A hit on an entry in state 01 leaves it unchanged and does not count as a miss. `err_o` goes high for exactly one cycle.
- R12: A write is accepted on an edge where `wr_valid_i` is high and `busy_o` is low. `busy_o` is high in the following cycle and for as long as a forward is outstanding. State, count, error and forward results appear after the edge that follows the acceptance edge.
- R13: The whole 25-bit ID takes part in the match, including the source bits 12:10 of software-generated IDs. ID 0x405 does not match an entry holding ID 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Guest deactivate write request |
| wr_data_i | input | 32 | Guest write word; ID in bits 24:0 |
| eoi_mode_i | input | 1 | Split deactivate mode; writes act only when 1 |
| busy_o | output | 1 | New writes held off while high |
| lr_we_i | input | 1 | Load one list entry |
| lr_idx_i | input | 2 | Index of the entry to load |
| lr_vid_i | input | 25 | Virtual ID to load |
| lr_state_i | input | 2 | State to load |
| lr_hw_i | input | 1 | Physical-backing flag to load |
| lr_pid_i | input | 13 | Physical ID to load |
| lr_grp_i | input | 1 | Physical group bit to load (1 = Group 1) |
| lr_state_o | output | 8 | State of entry i in bits 2i+1:2i |
| pd_valid_o | output | 1 | Physical deactivate request valid |
| pd_pid_o | output | 13 | Physical ID to deactivate |
| pd_ready_i | input | 1 | Distributor accepts the request |
| miss_cnt_o | output | 5 | Miss count |
| maint_en_i | input | 1 | Maintenance interrupt enable |
| cnt_clr_i | input | 1 | Clear the miss count |
| maint_irq_o | output | 1 | Maintenance interrupt |
| err_o | output | 1 | One-cycle pulse on a hit against a pending-only entry |

## Verification
The bench builds the block with its defaults: four entries and a 5-bit miss count. Four entries let all four states sit in the bank at once, and they allow two entries to carry the same ID so the lowest-index priority can be exercised. The 5-bit count is small enough to reach the wrap from 31 to 0 with 32 plain misses. A stalled distributor port is held for several cycles, which covers both the hold-off of new writes and the stability of the forwarded ID.

// File: rtl/vdeact_pkg.sv
package vdeact_pkg;

  localparam int VID_W = 25;
  localparam int PID_W = 13;
  localparam int REQ_W = 32;

  localparam logic [VID_W-1:0] SPEC_LO = VID_W'(1020);
  localparam logic [VID_W-1:0] SPEC_HI = VID_W'(1023);

  typedef enum logic [1:0] {
    ST_INV     = 2'b00,
    ST_PEND    = 2'b01,
    ST_ACT     = 2'b10,
    ST_ACTPEND = 2'b11
  } lr_state_e;

  typedef struct packed {
    logic [VID_W-1:0] vid;
    lr_state_e        state;
    logic             hw;
    logic [PID_W-1:0] pid;
    logic             grp1;
  } lr_entry_t;

endpackage

// File: rtl/vdeact_lookup.sv
module vdeact_lookup
  import vdeact_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  lr_entry_t [NUM_LR-1:0] bank_i,
  input  logic [VID_W-1:0]       id_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [NUM_LR-1:0]      grant_o
);

  logic              special;
  logic [NUM_LR-1:0] match;

  assign special = (id_i >= SPEC_LO) && (id_i <= SPEC_HI);

  // Per-entry comparators.
  for (genvar g = 0; g < NUM_LR; g++) begin : g_cmp
    assign match[g] = !special && (bank_i[g].state != ST_INV) &&
                      (bank_i[g].vid == id_i);
  end

  // Lowest index wins.
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    hit_o   = 1'b0;
    for (int i = 0; i < NUM_LR; i++) begin
      if (match[i] && !hit_o) begin
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
        hit_o      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vdeact_miss_ctr.sv
module vdeact_miss_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_inc_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |=> (cnt_o == $past(cnt_o) + ONE));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/vdeact_fwd.sv
module vdeact_fwd #(
  parameter int PID_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [PID_W-1:0] pid_o
);

  logic             valid_q, valid_d;
  logic [PID_W-1:0] pid_q;

  always_comb begin
    valid_d = valid_q;
    if (valid_q && ready_i) valid_d = 1'b0;
    if (req_i)              valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pid_q <= '0;
    else if (req_i) pid_q <= pid_i;
  end

  assign valid_o = valid_q;
  assign pid_o   = pid_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(pid_o)));

  p_no_overrun_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> !valid_o);

endmodule

// File: rtl/vdeact_unit.sv
module vdeact_unit
  import vdeact_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int CNT_W  = 5,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid_i,
  input  logic [REQ_W-1:0]      wr_data_i,
  input  logic                  eoi_mode_i,
  output logic                  busy_o,
  input  logic                  lr_we_i,
  input  logic [IDX_W-1:0]      lr_idx_i,
  input  logic [VID_W-1:0]      lr_vid_i,
  input  logic [1:0]            lr_state_i,
  input  logic                  lr_hw_i,
  input  logic [PID_W-1:0]      lr_pid_i,
  input  logic                  lr_grp_i,
  output logic [2*NUM_LR-1:0]   lr_state_o,
  output logic                  pd_valid_o,
  output logic [PID_W-1:0]      pd_pid_o,
  input  logic                  pd_ready_i,
  output logic [CNT_W-1:0]      miss_cnt_o,
  input  logic                  maint_en_i,
  input  logic                  cnt_clr_i,
  output logic                  maint_irq_o,
  output logic                  err_o
);

  lr_entry_t [NUM_LR-1:0] bank_q, bank_d;
  logic                   req_vld_q, req_mode_q;
  logic [VID_W-1:0]       req_id_q;
  logic                   accept, act;
  logic                   hit;
  logic [IDX_W-1:0]       hit_idx;
  logic [NUM_LR-1:0]      grant;
  logic                   miss_inc, err_d, err_q, fwd_req;
  logic [REQ_W-VID_W-1:0] unused_rsvd;

  assign unused_rsvd = wr_data_i[REQ_W-1:VID_W];
  assign accept      = wr_valid_i && !busy_o;
  assign act         = req_vld_q && req_mode_q;

  // Request stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_vld_q <= 1'b0;
    else        req_vld_q <= accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_id_q   <= '0;
      req_mode_q <= 1'b0;
    end else if (accept) begin
      req_id_q   <= wr_data_i[VID_W-1:0];
      req_mode_q <= eoi_mode_i;
    end
  end

  vdeact_lookup #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_lookup (
    .bank_i  (bank_q),
    .id_i    (req_id_q),
    .hit_o   (hit),
    .idx_o   (hit_idx),
    .grant_o (grant)
  );

  // Next-state for the bank and the side effects.
  always_comb begin
    bank_d   = bank_q;
    miss_inc = 1'b0;
    err_d    = 1'b0;
    fwd_req  = 1'b0;
    if (act) begin
      if (hit) begin
        case (bank_q[hit_idx].state)
          ST_ACT: begin
            bank_d[hit_idx].state = ST_INV;
            fwd_req = bank_q[hit_idx].hw && bank_q[hit_idx].grp1;
          end
          ST_ACTPEND: begin
            bank_d[hit_idx].state = ST_PEND;
            fwd_req = bank_q[hit_idx].hw && bank_q[hit_idx].grp1;
          end
          default: err_d = 1'b1;
        endcase
      end else begin
        miss_inc = 1'b1;
      end
    end
    if (lr_we_i) begin
      bank_d[lr_idx_i].vid   = lr_vid_i;
      bank_d[lr_idx_i].state = lr_state_e'(lr_state_i);
      bank_d[lr_idx_i].hw    = lr_hw_i;
      bank_d[lr_idx_i].pid   = lr_pid_i;
      bank_d[lr_idx_i].grp1  = lr_grp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      err_q  <= 1'b0;
    end else begin
      bank_q <= bank_d;
      err_q  <= err_d;
    end
  end

  vdeact_miss_ctr #(.CNT_W(CNT_W)) u_miss (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (miss_inc),
    .clr_i (cnt_clr_i),
    .cnt_o (miss_cnt_o)
  );

  vdeact_fwd #(.PID_W(PID_W)) u_fwd (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (fwd_req),
    .pid_i   (bank_q[hit_idx].pid),
    .ready_i (pd_ready_i),
    .valid_o (pd_valid_o),
    .pid_o   (pd_pid_o)
  );

  for (genvar g = 0; g < NUM_LR; g++) begin : g_state_out
    assign lr_state_o[2*g +: 2] = bank_q[g].state;
  end

  assign busy_o      = req_vld_q || pd_valid_o;
  assign maint_irq_o = maint_en_i && (miss_cnt_o != '0);
  assign err_o       = err_q;

  p_single_stage_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld_q |=> !req_vld_q);

  p_fwd_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_valid_o) |-> $past(act));

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_q && !req_mode_q && !lr_we_i && !cnt_clr_i) |=>
      ($stable(lr_state_o) && $stable(miss_cnt_o) && !err_o));

endmodule

// File: tb/test_vdeact_unit.sv
module test_vdeact_unit;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_valid_i, eoi_mode_i, busy_o;
  logic [31:0]  wr_data_i;
  logic         lr_we_i, lr_hw_i, lr_grp_i;
  logic [1:0]   lr_idx_i, lr_state_i;
  logic [24:0]  lr_vid_i;
  logic [12:0]  lr_pid_i, pd_pid_o;
  logic [7:0]   lr_state_o;
  logic         pd_valid_o, pd_ready_i;
  logic [4:0]   miss_cnt_o;
  logic         maint_en_i, cnt_clr_i, maint_irq_o, err_o;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  logic [12:0] exp_q[$];
  logic [12:0] mon_e;

  always #10 clk = ~clk;

  vdeact_unit i_vdeact_unit (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .eoi_mode_i(eoi_mode_i), .busy_o(busy_o), .lr_we_i(lr_we_i),
    .lr_idx_i(lr_idx_i), .lr_vid_i(lr_vid_i), .lr_state_i(lr_state_i),
    .lr_hw_i(lr_hw_i), .lr_pid_i(lr_pid_i), .lr_grp_i(lr_grp_i),
    .lr_state_o(lr_state_o), .pd_valid_o(pd_valid_o), .pd_pid_o(pd_pid_o),
    .pd_ready_i(pd_ready_i), .miss_cnt_o(miss_cnt_o), .maint_en_i(maint_en_i),
    .cnt_clr_i(cnt_clr_i), .maint_irq_o(maint_irq_o), .err_o(err_o)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int st(int i);
    return int'(lr_state_o[2*i +: 2]);
  endfunction

  task automatic load(int idx, int vid, int s, bit hw, int pid, bit g);
    @(negedge clk);
    lr_we_i = 1'b1; lr_idx_i = 2'(idx); lr_vid_i = 25'(vid);
    lr_state_i = 2'(s); lr_hw_i = hw; lr_pid_i = 13'(pid); lr_grp_i = g;
    @(negedge clk);
    lr_we_i = 1'b0;
  endtask

  // Ends at the negedge after the update edge.
  task automatic wr(logic [31:0] d, bit mode);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    wr_valid_i = 1'b1; wr_data_i = d; eoi_mode_i = mode;
    @(negedge clk);
    wr_valid_i = 1'b0;
    chk(busy_o == 1'b1, "R12 busy after accept", int'(busy_o), 1);
    @(negedge clk);
  endtask

  // Scoreboard monitor for the physical deactivate port.
  always @(negedge clk) begin
    if (rst_n && pd_valid_o && pd_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected forward", int'(pd_pid_o), -1);
      end else begin
        mon_e = exp_q.pop_front();
        chk(pd_pid_o == mon_e, "R6 forwarded id", int'(pd_pid_o), int'(mon_e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid_i = 1'b0; wr_data_i = '0; eoi_mode_i = 1'b1;
    lr_we_i = 1'b0; lr_idx_i = '0; lr_vid_i = '0; lr_state_i = '0;
    lr_hw_i = 1'b0; lr_pid_i = '0; lr_grp_i = 1'b0; pd_ready_i = 1'b1;
    maint_en_i = 1'b0; cnt_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lr_state_o == 8'h00, "R2 reset states", int'(lr_state_o), 0);
    chk(miss_cnt_o == 0 && !pd_valid_o && !busy_o && !err_o && !maint_irq_o,
        "R12 reset outputs", int'(miss_cnt_o), 0);

    load(0, 32, 2, 1'b1, 100, 1'b1);
    load(1, 40, 3, 1'b0, 0, 1'b1);
    load(2, 50, 1, 1'b0, 0, 1'b1);
    load(3, 60, 2, 1'b1, 200, 1'b0);

    // R1 R2 R6: reserved bits set, active hw-linked Group 1 entry.
    exp_q.push_back(13'd100);
    wr(32'hFE00_0020, 1'b1);
    chk(st(0) == 0, "R1 R2 active to invalid", st(0), 0);
    chk(pd_valid_o && pd_pid_o == 100, "R6 forward raised", int'(pd_pid_o), 100);

    wr(32'd40, 1'b1);
    chk(st(1) == 1, "R3 active-pending to pending", st(1), 1);

    wr(32'd50, 1'b1);
    chk(err_o == 1'b1, "R11 error pulse", int'(err_o), 1);
    chk(st(2) == 1 && miss_cnt_o == 0, "R11 pending unchanged, no miss", st(2), 1);
    @(negedge clk);
    chk(err_o == 1'b0, "R11 pulse one cycle", int'(err_o), 0);

    wr(32'd60, 1'b1);
    chk(st(3) == 0 && !pd_valid_o, "R7 group0 retired, not forwarded", st(3), 0);

    // R8: mode off.
    load(0, 32, 2, 1'b1, 100, 1'b1);
    wr(32'd32, 1'b0);
    chk(st(0) == 2, "R8 state kept with mode off", st(0), 2);
    chk(miss_cnt_o == 0 && !pd_valid_o && !err_o, "R8 no side effect", int'(miss_cnt_o), 0);
    wr(32'd99, 1'b0);
    chk(miss_cnt_o == 0, "R8 miss not counted with mode off", int'(miss_cnt_o), 0);

    // R9: special ID never matches.
    load(2, 1021, 2, 1'b0, 0, 1'b1);
    wr(32'd1021, 1'b1); exp_cnt++;
    chk(st(2) == 2, "R9 special id entry untouched", st(2), 2);
    chk(miss_cnt_o == exp_cnt, "R9 special id is miss", int'(miss_cnt_o), exp_cnt);

    wr(32'd99, 1'b1); exp_cnt++;
    chk(miss_cnt_o == exp_cnt, "R4 miss counted", int'(miss_cnt_o), exp_cnt);
    chk(maint_irq_o == 1'b0, "R5 irq off when disabled", int'(maint_irq_o), 0);
    maint_en_i = 1'b1;
    @(negedge clk);
    chk(maint_irq_o == 1'b1, "R5 irq on", int'(maint_irq_o), 1);
    cnt_clr_i = 1'b1;
    @(negedge clk);
    cnt_clr_i = 1'b0; exp_cnt = 0;
    chk(miss_cnt_o == 0 && !maint_irq_o, "R4 R5 clear", int'(miss_cnt_o), 0);

    // R4 wrap.
    for (int k = 0; k < 31; k++) wr(32'd99, 1'b1);
    chk(miss_cnt_o == 31, "R4 count to 31", int'(miss_cnt_o), 31);
    wr(32'd99, 1'b1);
    chk(miss_cnt_o == 0, "R4 wrap to 0", int'(miss_cnt_o), 0);

    // R10 duplicates.
    load(1, 77, 2, 1'b0, 0, 1'b1);
    load(2, 77, 2, 1'b0, 0, 1'b1);
    wr(32'd77, 1'b1);
    chk(st(1) == 0 && st(2) == 2, "R10 lowest index first", st(2), 2);
    wr(32'd77, 1'b1);
    chk(st(2) == 0, "R10 next match", st(2), 0);

    // R13 source bits.
    load(3, 5, 2, 1'b0, 0, 1'b1);
    wr(32'h0000_0405, 1'b1);
    chk(st(3) == 2 && miss_cnt_o == 1, "R13 source bits differ", st(3), 2);
    wr(32'd5, 1'b1);
    chk(st(3) == 0, "R13 exact id matches", st(3), 0);

    // R6 R12 stalled distributor.
    load(0, 32, 2, 1'b1, 300, 1'b1);
    pd_ready_i = 1'b0;
    exp_q.push_back(13'd300);
    wr(32'd32, 1'b1);
    repeat (3) @(negedge clk);
    chk(pd_valid_o && pd_pid_o == 300, "R6 held while not ready", int'(pd_pid_o), 300);
    chk(busy_o == 1'b1, "R12 busy while forward outstanding", int'(busy_o), 1);
    pd_ready_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!pd_valid_o && !busy_o, "R12 released after handshake", int'(busy_o), 0);
    chk(exp_q.size() == 0, "R6 all forwards seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule